// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Array with Line Locking

This block holds the tag, data and replacement state of a small two-way set-associative cache. Each line is 32 bytes (eight 32-bit words), and every access moves one 64-bit doubleword. A lookup presents a set index, a doubleword select, a physical tag and an operation. Both ways of the set are compared in the same cycle, and the result is registered on the next clock edge. The index comes from the untranslated address, so the tag compare runs alongside address translation elsewhere.

A separate fill port writes a whole line. The fill side delivers the line's parity bits together with the line, so the protection runs end to end. A fill can mark its line as locked. A locked line is never picked as a victim afterwards, so critical code or data stays resident until reset. Among unlocked ways, the victim is an empty way if there is one, otherwise the way named by a per-set LRU bit. When both ways of a set are locked, the fill is acknowledged but nothing is stored.

Every byte of data has an even parity bit, and every tag has one parity bit over all of its bits. Any mismatch turns the access into a miss and raises an error flag. The overall capacity is a parameter.

Top module: `tw_cache`

## Requirements
- R1: After reset every line is invalid and unlocked, and all registered outputs are zero. A lookup to any set then misses with no error.
- R2: A read lookup that hits reports res_hit=1, the hitting way on res_way and the selected doubleword on res_rdata, one clock after it is presented. Doubleword k covers line bytes 8k..8k+7, and byte 0 is the least significant byte of the 256-bit line.
- R3: A write lookup that hits replaces only the bytes whose lk_be bit is set (bit i selects bits 8i+7:8i of lk_wdata) and stores fresh parity for them. A write reports res_rdata=0.
- R4: A fill picks the first invalid way (way 0 before way 1). When both ways are valid and unlocked, it picks the way named by the set's LRU bit. Every hit and every fill on way w sets that bit to the other way.
- R5: A line filled with rf_lock=1 stays locked until reset and is never chosen as victim. With one way locked, fills always go to the other way.
- R6: A fill to a set whose two ways are both locked returns fill_done=1 and fill_alloc=0, and it changes no stored line.
- R7: A data parity mismatch in the doubleword selected on the matching way gives res_perr=1 and res_hit=0. Such a write stores nothing. Parity bit i of rf_dpar is the XOR of byte i of rf_data.
- R8: A tag parity mismatch in any valid way of the looked-up set gives res_perr=1 and res_hit=0. rf_tpar is the XOR of all bits of rf_tag.
- R9: When a fill and a lookup arrive in the same cycle, the fill is performed and the lookup is dropped: res_valid stays 0.
- R10: A write lookup that misses allocates no line. A later fill to that set still finds the same invalid way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | 1 = write, 0 = read |
| lk_index | input | IDX_W | Set index |
| lk_dw | input | 2 | Doubleword within the line |
| lk_tag | input | TAG_W | Physical tag to compare |
| lk_be | input | 8 | Byte enables for writes |
| lk_wdata | input | 64 | Write data |
| rf_valid | input | 1 | Fill request |
| rf_index | input | IDX_W | Set to fill |
| rf_tag | input | TAG_W | Tag of the filled line |
| rf_tpar | input | 1 | Parity of rf_tag |
| rf_lock | input | 1 | Lock the filled line |
| rf_data | input | 256 | Line data |
| rf_dpar | input | 32 | Per-byte parity of rf_data |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Lookup hit with clean parity |
| res_perr | output | 1 | Parity error seen on the lookup |
| res_way | output | 1 | Hitting way |
| res_rdata | output | 64 | Read doubleword |
| fill_done | output | 1 | Fill acknowledged |
| fill_alloc | output | 1 | Fill stored a line |
| fill_way | output | 1 | Way that received the fill |

## Verification
The bench fills one set with a locked line and then steers the LRU bit toward that locked way. A design that honoured only LRU would evict the locked line. It fills a set whose two ways are both locked, which a careless design would overwrite. It issues a write miss and follows it with a fill, which exposes any hidden write allocation because the fill would then land in the wrong way. It injects a bad data parity bit and a bad tag parity bit. A design that checked the wrong bytes, only the matching way's tag, or still wrote on an error would report a hit, or would clear the error on a later read. Finally, a fill and a lookup are presented in the same cycle, where a design without the ordering rule would report a stale lookup.

// File: rtl/tw_cache_pkg.sv
package tw_cache_pkg;
    localparam int WAYS        = 2;
    localparam int LINE_BYTES  = 32;
    localparam int LINE_BITS   = LINE_BYTES * 8;
    localparam int DW_BYTES    = 8;
    localparam int DW_BITS     = DW_BYTES * 8;
    localparam int DW_PER_LINE = LINE_BYTES / DW_BYTES;
    localparam int DW_SEL_W    = $clog2(DW_PER_LINE);
endpackage

// File: rtl/tw_par_gen.sv
module tw_par_gen #(
    parameter int NB = 8
) (
    input  logic [NB*8-1:0] data,
    output logic [NB-1:0]   par
);
    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign par[b] = ^data[b*8 +: 8];
    end
endmodule

// File: rtl/tw_way_cmp.sv
module tw_way_cmp #(
    parameter int TAG_W = 10
) (
    input  logic             vld,
    input  logic [TAG_W-1:0] tag_q,
    input  logic             tpar_q,
    input  logic [TAG_W-1:0] tag_i,
    output logic             match,
    output logic             tperr
);
    assign match = vld && (tag_q == tag_i);
    assign tperr = vld && ((^tag_q) != tpar_q);
endmodule

// File: rtl/tw_victim_sel.sv
module tw_victim_sel (
    input  logic [1:0] vld,
    input  logic [1:0] lock,
    input  logic       lru,
    output logic       alloc,
    output logic       way
);
    always_comb begin
        alloc = 1'b1;
        way   = 1'b0;
        if (&lock) begin
            alloc = 1'b0;
        end else if (lock[0]) begin
            way = 1'b1;
        end else if (lock[1]) begin
            way = 1'b0;
        end else if (!vld[0]) begin
            way = 1'b0;
        end else if (!vld[1]) begin
            way = 1'b1;
        end else begin
            way = lru;
        end
    end
endmodule

// File: rtl/tw_cache.sv
module tw_cache
    import tw_cache_pkg::*;
#(
    parameter int CACHE_BYTES = 256,
    parameter int TAG_W       = 10,
    localparam int SETS       = CACHE_BYTES / (WAYS * LINE_BYTES),
    localparam int IDX_W      = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lk_valid,
    input  logic                 lk_write,
    input  logic [IDX_W-1:0]     lk_index,
    input  logic [DW_SEL_W-1:0]  lk_dw,
    input  logic [TAG_W-1:0]     lk_tag,
    input  logic [DW_BYTES-1:0]  lk_be,
    input  logic [DW_BITS-1:0]   lk_wdata,
    input  logic                 rf_valid,
    input  logic [IDX_W-1:0]     rf_index,
    input  logic [TAG_W-1:0]     rf_tag,
    input  logic                 rf_tpar,
    input  logic                 rf_lock,
    input  logic [LINE_BITS-1:0] rf_data,
    input  logic [LINE_BYTES-1:0] rf_dpar,
    output logic                 res_valid,
    output logic                 res_hit,
    output logic                 res_perr,
    output logic                 res_way,
    output logic [DW_BITS-1:0]   res_rdata,
    output logic                 fill_done,
    output logic                 fill_alloc,
    output logic                 fill_way
);
    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]                 vld;
        logic [SETS-1:0][WAYS-1:0]                 lock;
        logic [SETS-1:0]                           lru;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]      tag;
        logic [SETS-1:0][WAYS-1:0]                 tpar;
        logic [SETS-1:0][WAYS-1:0][LINE_BITS-1:0]  data;
        logic [SETS-1:0][WAYS-1:0][LINE_BYTES-1:0] dpar;
        logic                                      res_valid;
        logic                                      res_hit;
        logic                                      res_perr;
        logic                                      res_way;
        logic [DW_BITS-1:0]                        res_rdata;
        logic                                      fill_done;
        logic                                      fill_alloc;
        logic                                      fill_way;
    } st_t;

    st_t st_d, st_q;

    logic [WAYS-1:0]     way_match;
    logic [WAYS-1:0]     way_tperr;
    logic                hit_any;
    logic                hit_way;
    logic [DW_BITS-1:0]  hit_dw;
    logic [DW_BYTES-1:0] hit_dp;
    logic [DW_BYTES-1:0] calc_dp;
    logic [DW_BITS-1:0]  merged;
    logic [DW_BYTES-1:0] merged_par;
    logic                dperr;
    logic                perr;
    logic                hit;
    logic                vic_alloc;
    logic                vic_way;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tw_way_cmp #(.TAG_W(TAG_W)) u_cmp (
            .vld    (st_q.vld[lk_index][w]),
            .tag_q  (st_q.tag[lk_index][w]),
            .tpar_q (st_q.tpar[lk_index][w]),
            .tag_i  (lk_tag),
            .match  (way_match[w]),
            .tperr  (way_tperr[w])
        );
    end

    assign hit_any = |way_match;
    assign hit_way = way_match[1];
    assign hit_dw  = st_q.data[lk_index][hit_way][{lk_dw, 6'b0} +: DW_BITS];
    assign hit_dp  = st_q.dpar[lk_index][hit_way][{lk_dw, 3'b0} +: DW_BYTES];

    tw_par_gen #(.NB(DW_BYTES)) u_rd_par (.data(hit_dw), .par(calc_dp));

    always_comb begin
        for (int b = 0; b < DW_BYTES; b++) begin
            merged[b*8 +: 8] = lk_be[b] ? lk_wdata[b*8 +: 8] : hit_dw[b*8 +: 8];
        end
    end

    tw_par_gen #(.NB(DW_BYTES)) u_wr_par (.data(merged), .par(merged_par));

    assign dperr = hit_any && (calc_dp != hit_dp);
    assign perr  = (|way_tperr) || dperr;
    assign hit   = hit_any && !perr;

    tw_victim_sel u_vic (
        .vld   (st_q.vld[rf_index]),
        .lock  (st_q.lock[rf_index]),
        .lru   (st_q.lru[rf_index]),
        .alloc (vic_alloc),
        .way   (vic_way)
    );

    always_comb begin
        st_d            = st_q;
        st_d.res_valid  = 1'b0;
        st_d.res_hit    = 1'b0;
        st_d.res_perr   = 1'b0;
        st_d.res_way    = 1'b0;
        st_d.res_rdata  = '0;
        st_d.fill_done  = 1'b0;
        st_d.fill_alloc = 1'b0;
        st_d.fill_way   = 1'b0;
        if (rf_valid) begin
            st_d.fill_done  = 1'b1;
            st_d.fill_alloc = vic_alloc;
            if (vic_alloc) begin
                st_d.fill_way                    = vic_way;
                st_d.vld[rf_index][vic_way]      = 1'b1;
                st_d.lock[rf_index][vic_way]     = rf_lock;
                st_d.tag[rf_index][vic_way]      = rf_tag;
                st_d.tpar[rf_index][vic_way]     = rf_tpar;
                st_d.data[rf_index][vic_way]     = rf_data;
                st_d.dpar[rf_index][vic_way]     = rf_dpar;
                st_d.lru[rf_index]               = ~vic_way;
            end
        end else if (lk_valid) begin
            st_d.res_valid = 1'b1;
            st_d.res_hit   = hit;
            st_d.res_perr  = perr;
            if (hit) begin
                st_d.res_way       = hit_way;
                st_d.lru[lk_index] = ~hit_way;
                if (lk_write) begin
                    st_d.data[lk_index][hit_way][{lk_dw, 6'b0} +: DW_BITS]  = merged;
                    st_d.dpar[lk_index][hit_way][{lk_dw, 3'b0} +: DW_BYTES] = merged_par;
                end else begin
                    st_d.res_rdata = hit_dw;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid  = st_q.res_valid;
    assign res_hit    = st_q.res_hit;
    assign res_perr   = st_q.res_perr;
    assign res_way    = st_q.res_way;
    assign res_rdata  = st_q.res_rdata;
    assign fill_done  = st_q.fill_done;
    assign fill_alloc = st_q.fill_alloc;
    assign fill_way   = st_q.fill_way;

    for (genvar s = 0; s < SETS; s++) begin : g_lock_chk
        for (genvar w = 0; w < WAYS; w++) begin : g_w
            AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.lock[s][w] |=> st_q.lock[s][w]); // R5
        end
    end

    AST_VICTIM_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_valid && vic_alloc) |-> !st_q.lock[rf_index][vic_way]); // R5

    AST_FULL_LOCK_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_valid && (&st_q.lock[rf_index])) |=> (fill_done && !fill_alloc)); // R6

    AST_HIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> (res_valid && !res_perr)); // R7

    AST_FILL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rf_valid |=> (fill_done && !res_valid)); // R9

    AST_WRITE_MISS_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !rf_valid && !hit_any) |=> $stable(st_q.vld)); // R10
endmodule

// File: tb/test_tw_cache.sv
`timescale 1ns/1ps
module test_tw_cache;
    localparam int TAG_W = 10;
    localparam int IDX_W = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         lk_valid = 1'b0, lk_write = 1'b0;
    logic [IDX_W-1:0] lk_index = '0;
    logic [1:0]   lk_dw = '0;
    logic [TAG_W-1:0] lk_tag = '0;
    logic [7:0]   lk_be = '0;
    logic [63:0]  lk_wdata = '0;
    logic         rf_valid = 1'b0;
    logic [IDX_W-1:0] rf_index = '0;
    logic [TAG_W-1:0] rf_tag = '0;
    logic         rf_tpar = 1'b0, rf_lock = 1'b0;
    logic [255:0] rf_data = '0;
    logic [31:0]  rf_dpar = '0;
    logic         res_valid, res_hit, res_perr, res_way;
    logic [63:0]  res_rdata;
    logic         fill_done, fill_alloc, fill_way;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [255:0] shadow [4][2];

    always #2.5 clk = ~clk;

    tw_cache i_tw_cache (
        .clk, .rst_n, .lk_valid, .lk_write, .lk_index, .lk_dw, .lk_tag, .lk_be,
        .lk_wdata, .rf_valid, .rf_index, .rf_tag, .rf_tpar, .rf_lock, .rf_data,
        .rf_dpar, .res_valid, .res_hit, .res_perr, .res_way, .res_rdata,
        .fill_done, .fill_alloc, .fill_way
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  set;
        logic [1:0]  dw;
        logic [9:0]  tag;
        logic [7:0]  be;
        logic [63:0] wd;
        logic        hit;
        logic        way;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 2'd0, 2'd0, 10'd5, 8'h00, 64'h0, 1'b1, 1'b0},
        '{1'b0, 2'd0, 2'd3, 10'd6, 8'h00, 64'h0, 1'b1, 1'b1},
        '{1'b0, 2'd0, 2'd0, 10'd7, 8'h00, 64'h0, 1'b0, 1'b0},
        '{1'b0, 2'd0, 2'd2, 10'd5, 8'h00, 64'h0, 1'b1, 1'b0},
        '{1'b1, 2'd0, 2'd1, 10'd6, 8'h0F, 64'hA5A5_A5A5_1234_5678, 1'b1, 1'b1},
        '{1'b0, 2'd0, 2'd1, 10'd6, 8'h00, 64'h0, 1'b1, 1'b1}
    };

    function automatic logic [255:0] pat_line(input logic [9:0] tag, input int set);
        logic [255:0] l;
        for (int b = 0; b < 32; b++) l[b*8 +: 8] = 8'(int'(tag) * 13 + set * 51 + b * 5 + 3);
        return l;
    endfunction

    function automatic logic [31:0] line_par(input logic [255:0] l);
        logic [31:0] p;
        for (int b = 0; b < 32; b++) p[b] = ^l[b*8 +: 8];
        return p;
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_fill(input string req, input int set, input logic [9:0] tag, input logic lock,
                           input logic exp_alloc, input logic exp_way, input logic bad_t, input int bad_b);
        logic [31:0] p;
        @(negedge clk);
        rf_valid = 1'b1; rf_index = IDX_W'(set); rf_tag = tag; rf_lock = lock;
        rf_data = pat_line(tag, set);
        p = line_par(rf_data);
        if (bad_b >= 0) p[bad_b] = ~p[bad_b];
        rf_dpar = p;
        rf_tpar = (^tag) ^ bad_t;
        @(posedge clk); #1;
        rf_valid = 1'b0;
        chk(req, "fill_done", 64'(fill_done), 64'd1);
        chk(req, "fill_alloc", 64'(fill_alloc), 64'(exp_alloc));
        if (exp_alloc) begin
            chk(req, "fill_way", 64'(fill_way), 64'(exp_way));
            shadow[set][exp_way] = pat_line(tag, set);
        end
    endtask

    task automatic do_look(input string req, input logic wr, input int set, input int dw,
                           input logic [9:0] tag, input logic [7:0] be, input logic [63:0] wd,
                           input logic exp_hit, input logic exp_perr, input logic exp_way);
        logic [63:0] exp_rd;
        @(negedge clk);
        lk_valid = 1'b1; lk_write = wr; lk_index = IDX_W'(set); lk_dw = 2'(dw);
        lk_tag = tag; lk_be = be; lk_wdata = wd;
        @(posedge clk); #1;
        lk_valid = 1'b0;
        exp_rd = (exp_hit && !wr) ? shadow[set][exp_way][dw*64 +: 64] : 64'd0;
        chk(req, "res_valid", 64'(res_valid), 64'd1);
        chk(req, "res_hit", 64'(res_hit), 64'(exp_hit));
        chk(req, "res_perr", 64'(res_perr), 64'(exp_perr));
        if (exp_hit) chk(req, "res_way", 64'(res_way), 64'(exp_way));
        chk(req, "res_rdata", res_rdata, exp_rd);
        if (exp_hit && wr) begin
            for (int b = 0; b < 8; b++)
                if (be[b]) shadow[set][exp_way][dw*64 + b*8 +: 8] = wd[b*8 +: 8];
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R1", "res_valid", 64'(res_valid), 64'd0);
        chk("R1", "res_rdata", res_rdata, 64'd0);
        chk("R1", "fill_done", 64'(fill_done), 64'd0);
        do_look("R1", 1'b0, 0, 0, 10'd5, 8'h00, 64'd0, 1'b0, 1'b0, 1'b0);

        do_fill("R4", 0, 10'd5, 1'b0, 1'b1, 1'b0, 1'b0, -1);
        do_fill("R4", 0, 10'd6, 1'b0, 1'b1, 1'b1, 1'b0, -1);

        foreach (VECS[i]) begin
            do_look(VECS[i].wr ? "R3" : "R2", VECS[i].wr, int'(VECS[i].set), int'(VECS[i].dw),
                    VECS[i].tag, VECS[i].be, VECS[i].wd, VECS[i].hit, 1'b0, VECS[i].way);
        end

        // LRU now names way 0
        do_fill("R4", 0, 10'd7, 1'b0, 1'b1, 1'b0, 1'b0, -1);
        do_look("R4", 1'b0, 0, 0, 10'd5, 8'h00, 64'd0, 1'b0, 1'b0, 1'b0);
        do_look("R4", 1'b0, 0, 1, 10'd6, 8'h00, 64'd0, 1'b1, 1'b0, 1'b1);

        // locked way 0 in set 1, LRU steered toward it
        do_fill("R5", 1, 10'd20, 1'b1, 1'b1, 1'b0, 1'b0, -1);
        do_fill("R5", 1, 10'd21, 1'b0, 1'b1, 1'b1, 1'b0, -1);
        do_look("R5", 1'b0, 1, 0, 10'd21, 8'h00, 64'd0, 1'b1, 1'b0, 1'b1);
        do_fill("R5", 1, 10'd22, 1'b0, 1'b1, 1'b1, 1'b0, -1);
        do_look("R5", 1'b0, 1, 3, 10'd20, 8'h00, 64'd0, 1'b1, 1'b0, 1'b0);
        do_look("R5", 1'b0, 1, 0, 10'd21, 8'h00, 64'd0, 1'b0, 1'b0, 1'b0);
        do_look("R5", 1'b0, 1, 2, 10'd22, 8'h00, 64'd0, 1'b1, 1'b0, 1'b1);

        // both ways locked in set 2
        do_fill("R6", 2, 10'd30, 1'b1, 1'b1, 1'b0, 1'b0, -1);
        do_fill("R6", 2, 10'd31, 1'b1, 1'b1, 1'b1, 1'b0, -1);
        do_fill("R6", 2, 10'd32, 1'b0, 1'b0, 1'b0, 1'b0, -1);
        do_look("R6", 1'b0, 2, 0, 10'd32, 8'h00, 64'd0, 1'b0, 1'b0, 1'b0);
        do_look("R6", 1'b0, 2, 1, 10'd30, 8'h00, 64'd0, 1'b1, 1'b0, 1'b0);
        do_look("R6", 1'b0, 2, 3, 10'd31, 8'h00, 64'd0, 1'b1, 1'b0, 1'b1);

        // write miss in empty set 3
        do_look("R10", 1'b1, 3, 0, 10'd40, 8'hFF, 64'hDEAD_BEEF_0000_1111, 1'b0, 1'b0, 1'b0);
        do_look("R10", 1'b0, 3, 0, 10'd40, 8'h00, 64'd0, 1'b0, 1'b0, 1'b0);
        do_fill("R10", 3, 10'd40, 1'b0, 1'b1, 1'b0, 1'b0, -1);

        // data parity: byte 9 sits in doubleword 1
        do_fill("R7", 3, 10'd41, 1'b0, 1'b1, 1'b1, 1'b0, 9);
        do_look("R7", 1'b0, 3, 1, 10'd41, 8'h00, 64'd0, 1'b0, 1'b1, 1'b0);
        do_look("R7", 1'b0, 3, 0, 10'd41, 8'h00, 64'd0, 1'b1, 1'b0, 1'b1);
        do_look("R7", 1'b1, 3, 1, 10'd41, 8'hFF, 64'h0, 1'b0, 1'b1, 1'b0);
        do_look("R7", 1'b0, 3, 1, 10'd41, 8'h00, 64'd0, 1'b0, 1'b1, 1'b0);

        // tag parity: LRU names way 0
        do_fill("R8", 3, 10'd42, 1'b0, 1'b1, 1'b0, 1'b1, -1);
        do_look("R8", 1'b0, 3, 0, 10'd42, 8'h00, 64'd0, 1'b0, 1'b1, 1'b0);
        do_look("R8", 1'b0, 3, 0, 10'd41, 8'h00, 64'd0, 1'b0, 1'b1, 1'b0);

        // fill and lookup together in set 0 (LRU names way 0)
        @(negedge clk);
        rf_valid = 1'b1; rf_index = 2'd0; rf_tag = 10'd8; rf_lock = 1'b0;
        rf_data = pat_line(10'd8, 0); rf_dpar = line_par(rf_data); rf_tpar = ^rf_tag;
        lk_valid = 1'b1; lk_write = 1'b0; lk_index = 2'd0; lk_dw = 2'd0; lk_tag = 10'd6;
        @(posedge clk); #1;
        rf_valid = 1'b0; lk_valid = 1'b0;
        chk("R9", "res_valid", 64'(res_valid), 64'd0);
        chk("R9", "fill_done", 64'(fill_done), 64'd1);
        chk("R9", "fill_way", 64'(fill_way), 64'd0);
        shadow[0][0] = pat_line(10'd8, 0);
        do_look("R9", 1'b0, 0, 2, 10'd8, 8'h00, 64'd0, 1'b1, 1'b0, 1'b0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule